// File: doc/BRIEF.md
# Interrupt Deassertion Interval Controller

This block drives one interrupt request line from a group of level-sensitive pending inputs. After the line drops, it keeps the line low for a programmable quiet period before it lets the line rise again. This limits how often the host can be interrupted. The quiet period is counted in units of 10 µs. A prescaler derives those units from the system clock, and the clock frequency is a parameter.

A 32-bit configuration word is written through a simple write strobe and read back continuously. Its top byte holds the quiet period length. Writing zero to that byte cancels a running quiet period at once, so any source that is waiting fires straight away. A power-management event input is exempt from the quiet period and drives the line high whenever it is asserted.

Top module: `irq_holdoff_ctrl`

## Requirements
- R1: While `rst` is high, `irq_out` is 0 and `cfg_rdata` is 0. After reset the interval field is 0.
- R2: `cfg_rdata[31:24]` returns the last value written to `cfg_wdata[31:24]`, visible from the cycle after the write. `cfg_rdata[23:0]` always reads 0, whatever was written there.
- R3: With no quiet period running, a high bit on any `src_pend` input raises `irq_out` on the next clock edge. `irq_out` then stays high while any source stays pending.
- R4: `irq_out` falls on the clock edge after all `src_pend` bits and `pm_evt` are low.
- R5: The edge on which `irq_out` falls starts a quiet period of N×DIV cycles, where N is the interval field and DIV = CLK_HZ/100000. If a source is pending throughout, `irq_out` is sampled low for exactly N×DIV+1 cycles before it rises.
- R6: Writing 0 to the interval field during a quiet period ends that period on the write edge. A pending source then raises `irq_out` one clock edge later.
- R7: A high `pm_evt` raises `irq_out` on the next clock edge, even while a quiet period is running.
- R8: A new non-zero interval value sets the length of every quiet period that starts after the write.
- R9: With the interval field at 0, there is no hold-off. A source pending right after a fall re-raises `irq_out` after a single low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data; bits 31:24 are the interval |
| cfg_rdata | output | 32 | Configuration read-back; bits 23:0 are zero |
| src_pend | input | N_SRC | Level pending flags of the ordinary interrupt sources |
| pm_evt | input | 1 | Power-management event, exempt from hold-off |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Every result appears one clock edge after its cause: a new source or event raises the line one edge later, the last pending flag dropping lowers it one edge later, and a write shows in the read-back one edge later. A zero write clears the quiet counter on its own edge, and the line rises on the edge after that. The quiet period after a fall lasts N×DIV cycles, so with a source pending again straight away the bench expects N×DIV+1 low samples. The bench drives inputs and samples outputs on falling clock edges, so each check lands exactly on the predicted cycle and never on an edge.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;
  localparam int REG_W   = 32;
  localparam int IVL_W   = 8;
  localparam int IVL_LSB = 24;
  // frequency of the 10 us quiet-period unit
  localparam int UNIT_HZ = 100_000;

  function automatic int unsigned unit_div(input int unsigned clk_hz);
    return (clk_hz / UNIT_HZ) < 1 ? 1 : (clk_hz / UNIT_HZ);
  endfunction
endpackage

// File: rtl/irq_unit_prescaler.sv
module irq_unit_prescaler #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PRE_W = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == LAST);
endmodule

// File: rtl/irq_cfg_word.sv
module irq_cfg_word
  import irq_holdoff_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IVL_W-1:0] wr_ivl,
  output logic [IVL_W-1:0] ivl,
  output logic             zero_wr,
  output logic [REG_W-1:0] rdata
);
  logic [IVL_W-1:0] ivl_q;

  always_ff @(posedge clk) begin
    if (rst) ivl_q <= '0;
    else if (we) ivl_q <= wr_ivl;
  end

  assign ivl     = ivl_q;
  assign zero_wr = we && (wr_ivl == '0);
  assign rdata   = {ivl_q, {IVL_LSB{1'b0}}};
endmodule

// File: rtl/irq_quiet_timer.sv
module irq_quiet_timer
  import irq_holdoff_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [IVL_W-1:0] load_val,
  input  logic             tick,
  output logic [IVL_W-1:0] cnt,
  output logic             busy
);
  logic [IVL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - IVL_W'(1);
  end

  assign cnt  = cnt_q;
  assign busy = (cnt_q != '0);
endmodule

// File: rtl/irq_holdoff_ctrl.sv
module irq_holdoff_ctrl
  import irq_holdoff_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned N_SRC  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic [N_SRC-1:0] src_pend,
  input  logic             pm_evt,
  output logic             irq_out
);
  localparam int unsigned DIV = unit_div(CLK_HZ);

  logic [IVL_W-1:0] ivl;
  logic [IVL_W-1:0] quiet_cnt;
  logic             zero_wr;
  logic             busy;
  logic             tick;
  logic             any_pend;
  logic             irq_q;
  logic             irq_d;
  logic             fall;

  irq_cfg_word u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .wr_ivl  (cfg_wdata[IVL_LSB +: IVL_W]),
    .ivl     (ivl),
    .zero_wr (zero_wr),
    .rdata   (cfg_rdata)
  );

  assign any_pend = |src_pend;
  // exempt event always wins; ordinary sources wait out the quiet period
  assign irq_d = pm_evt || (any_pend && (irq_q || !busy));
  assign fall  = irq_q && !irq_d;

  irq_unit_prescaler #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (fall),
    .tick    (tick)
  );

  irq_quiet_timer u_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr      (zero_wr),
    .load     (fall),
    .load_val (ivl),
    .tick     (tick),
    .cnt      (quiet_cnt),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= irq_d;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irq_holdoff_chk.sv
module irq_holdoff_chk #(
  parameter int unsigned N_SRC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic [N_SRC-1:0] src_pend,
  input logic             pm_evt,
  input logic             irq_out,
  input logic [7:0]       quiet_cnt
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!irq_out && cfg_rdata == 32'h0));

  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[23:0] != 24'h0) |=> cfg_rdata[23:0] == 24'h0);

  // R3
  raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((|src_pend) && quiet_cnt == 8'h0 && !irq_out) |=> irq_out);

  // R4
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (src_pend == '0 && !pm_evt) |=> !irq_out);

  // R5
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet_cnt != 8'h0 && !pm_evt && !irq_out) |=> !irq_out);

  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[31:24] == 8'h0) |=> quiet_cnt == 8'h0);

  // R7
  pm_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    pm_evt |=> irq_out);
endmodule

bind irq_holdoff_ctrl irq_holdoff_chk #(.N_SRC(N_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .src_pend  (src_pend),
  .pm_evt    (pm_evt),
  .irq_out   (irq_out),
  .quiet_cnt (quiet_cnt)
);

// File: tb/tb_irq_holdoff_ctrl.sv
module tb_irq_holdoff_ctrl;
  localparam int unsigned CLK_HZ = 800_000;   // DIV = 8
  localparam int unsigned N_SRC  = 4;
  localparam int NV = 6;
  localparam int IVL_TAB [NV] = '{1, 3, 0, 5, 2, 7};
  localparam int SRC_TAB [NV] = '{1, 2, 4, 8, 3, 15};
  localparam int LOW_TAB [NV] = '{9, 25, 1, 41, 17, 57}; // N*8+1

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [N_SRC-1:0] src_pend = '0;
  logic        pm_evt = 1'b0;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_holdoff_ctrl #(.CLK_HZ(CLK_HZ), .N_SRC(N_SRC)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_pend(src_pend), .pm_evt(pm_evt),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = 32'h0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int low;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'h0, irq_out}, 32'h0);
    chk("R1 cfg in reset", cfg_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    src_pend = 4'b0001;
    @(negedge clk);
    chk("R3 first raise", {31'h0, irq_out}, 32'h1);

    // vector table: interval, source pattern, expected low samples
    for (int i = 0; i < NV; i++) begin
      wr({IVL_TAB[i][7:0], 24'h0});
      chk("R2 read back interval", cfg_rdata, {IVL_TAB[i][7:0], 24'h0});
      src_pend = '0;
      @(negedge clk);
      chk("R4 fall after release", {31'h0, irq_out}, 32'h0);
      src_pend = SRC_TAB[i][N_SRC-1:0];
      low = 1;
      for (int k = 0; k < 5000; k++) begin
        @(negedge clk);
        if (irq_out) break;
        low++;
      end
      // R5 R8 R9: low time follows the current interval value
      chk("R5/R8/R9 low time", low, LOW_TAB[i]);
      repeat (3) @(negedge clk);
      chk("R3 held while pending", {31'h0, irq_out}, 32'h1);
    end

    // R2 reserved bits ignore writes
    wr(32'hFFFF_FFFF);
    chk("R2 low bits zero", cfg_rdata, 32'hFF00_0000);

    // R6 zero write cancels a running interval
    wr(32'h6400_0000);
    src_pend = '0;
    @(negedge clk);
    src_pend = 4'b0100;
    repeat (20) @(negedge clk);
    chk("R6 held during interval", {31'h0, irq_out}, 32'h0);
    wr(32'h0);
    chk("R6 low on write edge", {31'h0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R6 fires after zero write", {31'h0, irq_out}, 32'h1);

    // R7 exempt event during an interval
    wr(32'h6400_0000);
    src_pend = '0;
    repeat (10) @(negedge clk);
    chk("R7 low before event", {31'h0, irq_out}, 32'h0);
    pm_evt = 1'b1;
    @(negedge clk);
    chk("R7 event bypasses hold-off", {31'h0, irq_out}, 32'h1);
    pm_evt = 1'b0;
    @(negedge clk);
    chk("R4 fall after event", {31'h0, irq_out}, 32'h0);
    src_pend = 4'b0010;
    repeat (5) @(negedge clk);
    chk("R5 source waits for interval", {31'h0, irq_out}, 32'h0);
    wr(32'h0);
    @(negedge clk);
    chk("R6 release after event", {31'h0, irq_out}, 32'h1);

    // R1 reset mid-run
    wr(32'h0500_0000);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
    chk("R1 cfg after reset", cfg_rdata, 32'h0);
    rst = 1'b0;
    src_pend = '0;
    @(negedge clk);
    finish_run();
  end
endmodule